// File: doc/BRIEF.md
# Core Interrupt Acceptance Arbiter

This block sits between a processor core and the sources of its interrupt requests. It holds the requests that are waiting, decides on every cycle whether one of them should be offered to the core, and reports which class of source wins and which 8-bit vector goes with it. Three request classes ignore the core's interrupt-enable flag: system-management, non-maskable and initialisation requests. External requests and fixed (vectored) requests are offered only while the enable flag is set.

Fixed requests are held as bits in a 256-entry request register and are written one vector at a time. A fixed request is offered only when its vector is above every vector now in service and when its priority class (the upper four bits of the vector) is above the class held in the task-priority input. When the core acknowledges an offer, the block retires the winning source. A fixed vector moves from the request register to the in-service register. An end-of-interrupt pulse retires the highest in-service vector.

Top module: `irq_accept_ctrl`

## Requirements
- R1: `irq_pending` is high in every cycle in which a system-management, non-maskable or initialisation request is held, whatever the value of `intr_en`.
- R2: While `intr_en` is low and none of those three requests is held, `irq_pending` is low, even when external or fixed requests are held.
- R3: The source codes on `irq_kind` are 0 none, 1 system-management, 2 non-maskable, 3 initialisation, 4 external, 5 fixed. System-management wins over non-maskable, and non-maskable wins over initialisation.
- R4: While `intr_en` is high, a held external request wins over any fixed request and loses to all three unmaskable classes.
- R5: A fixed request is offered only if the highest set request vector is strictly above the highest set in-service vector (0 when the in-service register is empty) and bits 7:4 of that vector are strictly above bits 7:4 of `task_prio`.
- R6: `irq_vector` is the vector captured with the latest non-maskable, initialisation or external request for those kinds, the highest request vector for a fixed offer, and 0 for a system-management offer. When nothing is offered, kind and vector are both 0.
- R7: An accepted acknowledge of an unmaskable offer clears only the highest-priority held one of the three. Any others stay held and are offered next.
- R8: An accepted acknowledge of an external offer clears the held external request.
- R9: An accepted acknowledge of a fixed offer sets the in-service bit of the offered vector and clears its request bit.
- R10: An `eoi` pulse clears the highest set in-service bit, which can then let a lower fixed request through.
- R11: `ack` is accepted only in a cycle in which `irq_pending` is high. `ack_done` is high in the cycle after each accepted acknowledge, and in no other cycle. An acknowledge that is not accepted changes no state.
- R12: After reset, nothing is held, `irq_pending` and `ack_done` are low, and kind and vector are 0.
- R13: A request pulse that arrives in the same cycle as the acknowledge that retires the same class leaves that class held, with the newly supplied vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_req | input | 1 | System-management request pulse |
| nmi_req | input | 1 | Non-maskable request pulse |
| nmi_vec | input | 8 | Vector captured with `nmi_req` |
| init_req | input | 1 | Initialisation request pulse |
| init_vec | input | 8 | Vector captured with `init_req` |
| ext_req | input | 1 | External request pulse |
| ext_vec | input | 8 | Vector captured with `ext_req` |
| fix_set | input | 1 | Set one bit of the fixed request register |
| fix_vec | input | 8 | Vector whose request bit `fix_set` sets |
| intr_en | input | 1 | Core interrupt-enable flag |
| task_prio | input | 8 | Task-priority value; bits 7:4 are the class threshold |
| eoi | input | 1 | End-of-interrupt pulse |
| ack | input | 1 | Core acknowledge of the current offer |
| irq_pending | output | 1 | An offer is presented to the core |
| irq_kind | output | 3 | Winning source code |
| irq_vector | output | 8 | Vector of the winning source |
| ack_done | output | 1 | Pulse one cycle after an accepted acknowledge |

## Verification
The unmaskable classes are raised together with the enable flag low and then acknowledged one at a time. This separates the fixed order among them from plain masking. External and fixed requests are put up against each other, and against a non-maskable request, with the enable flag both low and high, which shows how masking and ranking interact. The fixed path is driven with a class equal to the threshold, one class above it, a vector below an in-service vector, and nested service closed by end-of-interrupt pulses. These patterns separate strict from non-strict compares and show whether the in-service search takes the highest bit. Acknowledges during idle cycles, and request pulses that coincide with the acknowledge of the same class, check that a refused acknowledge changes no state and that a new request wins over a clear.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_SMI   = 3'd1,
        SRC_NMI   = 3'd2,
        SRC_INIT  = 3'd3,
        SRC_EXT   = 3'd4,
        SRC_FIXED = 3'd5
    } src_kind_e;

endpackage

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  bits_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    // Highest set index; 0 when no bit is set.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (bits_i[i]) idx_o = IW'(i);
        end
        any_o = |bits_i;
    end
endmodule

// File: rtl/irq_vec_decode.sv
module irq_vec_decode #(
    parameter int W  = 256,
    parameter int IW = $clog2(W)
) (
    input  logic          en_i,
    input  logic [IW-1:0] vec_i,
    output logic [W-1:0]  onehot_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign onehot_o[g] = en_i && (vec_i == IW'(g));
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_accept_pkg::*;
#(
    parameter int VW      = 8,
    parameter int CLS_LSB = 4
) (
    input  logic          smi_i,
    input  logic          nmi_i,
    input  logic          init_i,
    input  logic          ext_i,
    input  logic [VW-1:0] nmi_vec_i,
    input  logic [VW-1:0] init_vec_i,
    input  logic [VW-1:0] ext_vec_i,
    input  logic          enable_i,
    input  logic          irr_any_i,
    input  logic [VW-1:0] irr_top_i,
    input  logic [VW-1:0] isr_top_i,
    input  logic [VW-1:0] tpr_i,
    output logic          pend_o,
    output src_kind_e     kind_o,
    output logic [VW-1:0] vec_o
);
    logic fixed_ok;

    always_comb begin
        fixed_ok = irr_any_i
                && (irr_top_i > isr_top_i)
                && ((irr_top_i >> CLS_LSB) > (tpr_i >> CLS_LSB));
        kind_o = SRC_NONE;
        vec_o  = '0;
        if (smi_i) begin
            kind_o = SRC_SMI;
        end else if (nmi_i) begin
            kind_o = SRC_NMI;
            vec_o  = nmi_vec_i;
        end else if (init_i) begin
            kind_o = SRC_INIT;
            vec_o  = init_vec_i;
        end else if (enable_i && ext_i) begin
            kind_o = SRC_EXT;
            vec_o  = ext_vec_i;
        end else if (enable_i && fixed_ok) begin
            kind_o = SRC_FIXED;
            vec_o  = irr_top_i;
        end
        pend_o = (kind_o != SRC_NONE);
    end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
    import irq_accept_pkg::*;
#(
    parameter int NVEC    = 256,
    parameter int CLS_LSB = 4,
    parameter int VW      = $clog2(NVEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smi_req,
    input  logic          nmi_req,
    input  logic [VW-1:0] nmi_vec,
    input  logic          init_req,
    input  logic [VW-1:0] init_vec,
    input  logic          ext_req,
    input  logic [VW-1:0] ext_vec,
    input  logic          fix_set,
    input  logic [VW-1:0] fix_vec,
    input  logic          intr_en,
    input  logic [VW-1:0] task_prio,
    input  logic          eoi,
    input  logic          ack,
    output logic          irq_pending,
    output logic [2:0]    irq_kind,
    output logic [VW-1:0] irq_vector,
    output logic          ack_done
);
    typedef struct packed {
        logic            smi;
        logic            nmi;
        logic            init;
        logic            ext;
        logic [VW-1:0]   nmi_v;
        logic [VW-1:0]   init_v;
        logic [VW-1:0]   ext_v;
        logic [NVEC-1:0] irr;
        logic [NVEC-1:0] isr;
        logic            ack_done;
    } state_t;

    state_t st_q, st_d;

    logic [VW-1:0]   irr_top, isr_top, win_vec;
    logic            irr_any, isr_any, win_pend, take;
    src_kind_e       win_kind;
    logic [NVEC-1:0] set_oh, fix_oh, eoi_oh;

    // Signals observed by the bound checker.
    logic            smi_pend, nmi_pend, init_pend;
    logic [NVEC-1:0] isr_now;

    irq_msb_find #(.W(NVEC)) u_irr_top (
        .bits_i(st_q.irr), .idx_o(irr_top), .any_o(irr_any));
    irq_msb_find #(.W(NVEC)) u_isr_top (
        .bits_i(st_q.isr), .idx_o(isr_top), .any_o(isr_any));

    irq_arbiter #(.VW(VW), .CLS_LSB(CLS_LSB)) u_arb (
        .smi_i(st_q.smi), .nmi_i(st_q.nmi), .init_i(st_q.init), .ext_i(st_q.ext),
        .nmi_vec_i(st_q.nmi_v), .init_vec_i(st_q.init_v), .ext_vec_i(st_q.ext_v),
        .enable_i(intr_en), .irr_any_i(irr_any), .irr_top_i(irr_top),
        .isr_top_i(isr_top), .tpr_i(task_prio),
        .pend_o(win_pend), .kind_o(win_kind), .vec_o(win_vec));

    assign take = ack && win_pend;

    irq_vec_decode #(.W(NVEC)) u_set_dec (
        .en_i(fix_set), .vec_i(fix_vec), .onehot_o(set_oh));
    irq_vec_decode #(.W(NVEC)) u_fix_dec (
        .en_i(take && (win_kind == SRC_FIXED)), .vec_i(irr_top), .onehot_o(fix_oh));
    irq_vec_decode #(.W(NVEC)) u_eoi_dec (
        .en_i(eoi && isr_any), .vec_i(isr_top), .onehot_o(eoi_oh));

    always_comb begin
        st_d          = st_q;
        st_d.ack_done = take;
        // Retire the accepted source first; new requests below win over the clear.
        if (take) begin
            unique case (win_kind)
                SRC_SMI:  st_d.smi  = 1'b0;
                SRC_NMI:  st_d.nmi  = 1'b0;
                SRC_INIT: st_d.init = 1'b0;
                SRC_EXT:  st_d.ext  = 1'b0;
                default:  ;
            endcase
        end
        st_d.irr = (st_q.irr & ~fix_oh) | set_oh;
        st_d.isr = (st_q.isr | fix_oh) & ~eoi_oh;
        if (smi_req) st_d.smi = 1'b1;
        if (nmi_req) begin
            st_d.nmi   = 1'b1;
            st_d.nmi_v = nmi_vec;
        end
        if (init_req) begin
            st_d.init   = 1'b1;
            st_d.init_v = init_vec;
        end
        if (ext_req) begin
            st_d.ext   = 1'b1;
            st_d.ext_v = ext_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_pending = win_pend;
    assign irq_kind    = win_kind;
    assign irq_vector  = win_vec;
    assign ack_done    = st_q.ack_done;
    assign smi_pend    = st_q.smi;
    assign nmi_pend    = st_q.nmi;
    assign init_pend   = st_q.init;
    assign isr_now     = st_q.isr;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
    parameter int NVEC = 256,
    parameter int VW   = $clog2(NVEC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            intr_en,
    input logic            ack,
    input logic            irq_pending,
    input logic [2:0]      irq_kind,
    input logic [VW-1:0]   irq_vector,
    input logic            ack_done,
    input logic            smi_pend,
    input logic            nmi_pend,
    input logic            init_pend,
    input logic [NVEC-1:0] isr_now
);
    // R1
    unmask_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_pend || nmi_pend || init_pend) |-> irq_pending);

    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!intr_en && !smi_pend && !nmi_pend && !init_pend) |-> !irq_pending);

    // R3
    smi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smi_pend |-> (irq_kind == 3'd1 && irq_vector == '0));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pending |-> (irq_kind == 3'd0 && irq_vector == '0));

    // R9
    fixed_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_pending && irq_kind == 3'd5) |=> isr_now[$past(irq_vector)]);

    // R11
    ack_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_pending) |=> !ack_done);

    // R11
    ack_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_pending) |=> ack_done);
endmodule

bind irq_accept_ctrl irq_accept_chk #(.NVEC(NVEC)) u_chk (
    .clk(clk), .rst_n(rst_n), .intr_en(intr_en), .ack(ack),
    .irq_pending(irq_pending), .irq_kind(irq_kind), .irq_vector(irq_vector),
    .ack_done(ack_done), .smi_pend(smi_pend), .nmi_pend(nmi_pend),
    .init_pend(init_pend), .isr_now(isr_now));

// File: tb/sim_irq_accept_ctrl.sv
`timescale 1ns/1ps
module sim_irq_accept_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smi_req = 0, nmi_req = 0, init_req = 0, ext_req = 0, fix_set = 0;
    logic [7:0] nmi_vec = 0, init_vec = 0, ext_vec = 0, fix_vec = 0;
    logic       intr_en = 0, eoi = 0, ack = 0;
    logic [7:0] task_prio = 0;
    logic       irq_pending, ack_done;
    logic [2:0] irq_kind;
    logic [7:0] irq_vector;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    // Reference model state
    bit         m_smi, m_nmi, m_init, m_ext, m_ackd;
    int         m_nv, m_iv, m_ev;
    bit [255:0] m_irr, m_isr;

    always #2.5 clk = ~clk;

    irq_accept_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .smi_req(smi_req), .nmi_req(nmi_req), .nmi_vec(nmi_vec),
        .init_req(init_req), .init_vec(init_vec),
        .ext_req(ext_req), .ext_vec(ext_vec),
        .fix_set(fix_set), .fix_vec(fix_vec),
        .intr_en(intr_en), .task_prio(task_prio), .eoi(eoi), .ack(ack),
        .irq_pending(irq_pending), .irq_kind(irq_kind),
        .irq_vector(irq_vector), .ack_done(ack_done));

    function automatic int top_of(bit [255:0] b);
        int r = 0;
        for (int i = 0; i < 256; i++) if (b[i]) r = i;
        return r;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag);
        int ek, ev, ti, si;
        bit ep, take;
        @(negedge clk);
        ti = top_of(m_irr);
        si = top_of(m_isr);
        ek = 0; ev = 0;
        if (m_smi) ek = 1;
        else if (m_nmi) begin ek = 2; ev = m_nv; end
        else if (m_init) begin ek = 3; ev = m_iv; end
        else if (intr_en && m_ext) begin ek = 4; ev = m_ev; end
        else if (intr_en && m_irr != 0 && ti > si && (ti / 16) > (int'(task_prio) / 16)) begin
            ek = 5; ev = ti;
        end
        ep = (ek != 0);
        chk(tag, "pending", int'(irq_pending), int'(ep));
        chk(tag, "kind", int'(irq_kind), ek);
        chk(tag, "vector", int'(irq_vector), ev);
        chk(tag, "ack_done", int'(ack_done), int'(m_ackd));
        // model next state
        take = ack && ep;
        m_ackd = take;
        if (take) begin
            case (ek)
                1: m_smi = 0;
                2: m_nmi = 0;
                3: m_init = 0;
                4: m_ext = 0;
                5: begin m_isr[ti] = 1; m_irr[ti] = 0; end
                default: ;
            endcase
        end
        if (eoi && m_isr != 0) m_isr[si] = 0;
        if (fix_set) m_irr[fix_vec] = 1;
        if (smi_req) m_smi = 1;
        if (nmi_req) begin m_nmi = 1; m_nv = nmi_vec; end
        if (init_req) begin m_init = 1; m_iv = init_vec; end
        if (ext_req) begin m_ext = 1; m_ev = ext_vec; end
        @(posedge clk);
        #1;
        smi_req = 0; nmi_req = 0; init_req = 0; ext_req = 0;
        fix_set = 0; eoi = 0; ack = 0;
    endtask

    initial begin
        #500000;
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired (R12 run did not finish)");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        m_smi = 0; m_nmi = 0; m_init = 0; m_ext = 0; m_ackd = 0;
        m_nv = 0; m_iv = 0; m_ev = 0; m_irr = '0; m_isr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cyc("R12");
        cyc("R12");

        // Masked: external and fixed held with enable low
        fix_set = 1; fix_vec = 8'h50; cyc("R2");
        ext_req = 1; ext_vec = 8'h21; cyc("R2");
        ack = 1; cyc("R11");               // refused: nothing offered
        cyc("R11");

        // Unmaskable trio with enable low
        smi_req = 1; nmi_req = 1; nmi_vec = 8'h02; init_req = 1; init_vec = 8'h07;
        cyc("R1");
        cyc("R3");
        ack = 1; cyc("R7");                // retire system-management
        cyc("R6");                         // non-maskable with its vector
        ack = 1; cyc("R7");
        cyc("R3");
        ack = 1; cyc("R7");
        cyc("R2");                         // back to masked quiet

        // Enable: external beats fixed, loses to non-maskable
        intr_en = 1; cyc("R4");
        nmi_req = 1; nmi_vec = 8'h0B; cyc("R4");
        cyc("R4");
        ack = 1; cyc("R7");
        cyc("R4");
        ack = 1; cyc("R8");
        cyc("R8");                         // fixed 0x50 now offered

        // Task priority thresholds
        task_prio = 8'h5F; cyc("R5");      // class equal -> blocked
        task_prio = 8'h40; cyc("R5");
        ack = 1; cyc("R9");                // 0x50 in service
        cyc("R9");
        fix_set = 1; fix_vec = 8'h45; cyc("R5"); // below in service
        cyc("R5");
        fix_set = 1; fix_vec = 8'h60; cyc("R5");
        cyc("R6");
        ack = 1; cyc("R9");                // 0x60 in service
        cyc("R9");
        eoi = 1; cyc("R10");               // clears 0x60
        cyc("R10");
        eoi = 1; cyc("R10");               // clears 0x50
        cyc("R5");                         // 0x45 class 4 not above 4
        task_prio = 8'h30; cyc("R10");
        intr_en = 0; ack = 1; cyc("R11");  // refused while masked
        intr_en = 1; cyc("R11");
        ack = 1; cyc("R9");
        eoi = 1; cyc("R10");
        cyc("R10");

        // Same-cycle request and retire of the same class
        nmi_req = 1; nmi_vec = 8'h11; cyc("R13");
        ack = 1; nmi_req = 1; nmi_vec = 8'h12; cyc("R13");
        cyc("R13");
        ack = 1; cyc("R13");
        ext_req = 1; ext_vec = 8'h33; cyc("R13");
        ack = 1; ext_req = 1; ext_vec = 8'h34; cyc("R13");
        cyc("R13");
        ack = 1; cyc("R8");
        cyc("R12");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule